// File: doc/BRIEF.md
# Column-Compressor 4x4 Unsigned Multiplier

This block multiplies two 4-bit unsigned operands and returns the full 8-bit product. It has no clock and no state. All sixteen single-bit products (one multiplicand bit ANDed with one multiplier bit) are formed at once. Each product weight column is then reduced in a single step. The block never builds shifted partial-product rows and never adds such rows together.

Each column adds its own product terms and the carries that arrive from lower columns. The adder used depends on how many bits the column holds:

- a half adder for two bits,
- a full adder for three bits,
- a 4:3 counting compressor for four bits,
- a 5:3 counting compressor for five bits.

A compressor returns a sum bit and two carries. The weight-2 carry feeds the next column up. The weight-4 carry skips one column and feeds the column two places up. The top product bit is a plain XOR of the two carries that land on it, because the product of two 4-bit numbers always fits in eight bits.

The block suits a datapath that wants a small multiply with no latency. It can sit between registers that the surrounding logic already has.

Top module: `colmul4u`

## Requirements
- R1: Product bit 0 equals the AND of bit 0 of the multiplicand and bit 0 of the multiplier.
- R2: For every pair of unsigned operands in 0..15, the 8-bit product equals their arithmetic product.
- R3: Product bit 1 equals the XOR of (multiplicand bit 1 AND multiplier bit 0) with (multiplicand bit 0 AND multiplier bit 1).
- R4: The 4:3 compressor returns sum + 2*carry_lo + 4*carry_hi equal to the number of ones among its four inputs.
- R5: The 5:3 compressor returns sum + 2*carry_lo + 4*carry_hi equal to the number of ones among its five inputs.
- R6: The product never exceeds 225. Product bit 7 is set only when the product is 128 or more.
- R7: A zero on either operand gives a product of zero.
- R8: The block is combinational. The product reflects the operands in the same clock cycle in which they are applied, with no register in the path.
- R9: Swapping the two operands leaves the product unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand_i | input | 4 | Unsigned multiplicand |
| mplier_i | input | 4 | Unsigned multiplier |
| prod_o | output | 8 | Unsigned product |

## Verification
Every result of this block is due zero cycles after its operands change, because no register lies between the inputs and the product. The bench drives new operands just after a rising edge and samples the product at the following falling edge, inside the same cycle. The bench's own model is an integer multiply, and it is compared on every clock.

The two compressor types are also driven directly, with every input combination. Their outputs are checked against a bit count in that same cycle.

// File: rtl/colmul_pkg.sv
package colmul_pkg;
  localparam int OPW = 4;
  localparam int PRW = 2 * OPW;
  localparam int NPT = OPW * OPW;
  localparam int MAXPROD = ((1 << OPW) - 1) * ((1 << OPW) - 1);
endpackage

// File: rtl/cc_half_add.sv
module cc_half_add (
  input  logic x_i,
  input  logic y_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i;
  assign c_o = x_i & y_i;
endmodule

// File: rtl/cc_full_add.sv
module cc_full_add (
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  output logic s_o,
  output logic c_o
);
  logic xy;
  assign xy  = x_i ^ y_i;
  assign s_o = xy ^ z_i;
  assign c_o = (x_i & y_i) | (xy & z_i);
endmodule

// File: rtl/cc_pp_array.sv
module cc_pp_array #(
  parameter int W = 4
) (
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [W*W-1:0] terms_o
);
  // terms_o[i*W+j] = mcand bit i AND mplier bit j, weight 2^(i+j)
  for (genvar gi = 0; gi < W; gi++) begin : g_row
    for (genvar gj = 0; gj < W; gj++) begin : g_col
      assign terms_o[gi*W+gj] = mcand_i[gi] & mplier_i[gj];
    end
  end
endmodule

// File: rtl/cc_cmp43.sv
module cc_cmp43 (
  input  logic [3:0] in_i,
  output logic       sum_o,
  output logic       cy_lo_o,
  output logic       cy_hi_o
);
  logic s_mid, c_fa, c_ha;

  cc_full_add u_fa (
    .x_i(in_i[0]), .y_i(in_i[1]), .z_i(in_i[2]),
    .s_o(s_mid), .c_o(c_fa)
  );

  cc_half_add u_ha_sum (
    .x_i(s_mid), .y_i(in_i[3]),
    .s_o(sum_o), .c_o(c_ha)
  );

  cc_half_add u_ha_cy (
    .x_i(c_fa), .y_i(c_ha),
    .s_o(cy_lo_o), .c_o(cy_hi_o)
  );
endmodule

// File: rtl/cc_cmp53.sv
module cc_cmp53 (
  input  logic [4:0] in_i,
  output logic       sum_o,
  output logic       cy_lo_o,
  output logic       cy_hi_o
);
  logic s_mid, c_a, c_b;

  cc_full_add u_fa_a (
    .x_i(in_i[0]), .y_i(in_i[1]), .z_i(in_i[2]),
    .s_o(s_mid), .c_o(c_a)
  );

  cc_full_add u_fa_b (
    .x_i(s_mid), .y_i(in_i[3]), .z_i(in_i[4]),
    .s_o(sum_o), .c_o(c_b)
  );

  cc_half_add u_ha_cy (
    .x_i(c_a), .y_i(c_b),
    .s_o(cy_lo_o), .c_o(cy_hi_o)
  );
endmodule

// File: rtl/colmul4u.sv
module colmul4u
  import colmul_pkg::*;
(
  input  logic [OPW-1:0] mcand_i,
  input  logic [OPW-1:0] mplier_i,
  output logic [PRW-1:0] prod_o
);
  logic [NPT-1:0] t;   // t[i*OPW+j] has weight 2^(i+j)

  cc_pp_array #(.W(OPW)) u_pp (
    .mcand_i(mcand_i), .mplier_i(mplier_i), .terms_o(t)
  );

  // per-column sums and carries (lo = weight 2, hi = weight 4)
  logic s1, c1;
  logic s2, c2_lo, c2_hi;
  logic s3, c3_lo, c3_hi;
  logic s4, c4_lo, c4_hi;
  logic s5, c5_lo, c5_hi;
  logic s6, c6;

  // column 1: two terms
  cc_half_add u_col1 (
    .x_i(t[1*OPW+0]), .y_i(t[0*OPW+1]),
    .s_o(s1), .c_o(c1)
  );

  // column 2: carry + three terms
  cc_cmp43 u_col2 (
    .in_i({t[0*OPW+2], t[2*OPW+0], t[1*OPW+1], c1}),
    .sum_o(s2), .cy_lo_o(c2_lo), .cy_hi_o(c2_hi)
  );

  // column 3: carry + four terms
  cc_cmp53 u_col3 (
    .in_i({t[2*OPW+1], t[1*OPW+2], t[0*OPW+3], t[3*OPW+0], c2_lo}),
    .sum_o(s3), .cy_lo_o(c3_lo), .cy_hi_o(c3_hi)
  );

  // column 4: two carries + three terms
  cc_cmp53 u_col4 (
    .in_i({t[2*OPW+2], t[1*OPW+3], t[3*OPW+1], c2_hi, c3_lo}),
    .sum_o(s4), .cy_lo_o(c4_lo), .cy_hi_o(c4_hi)
  );

  // column 5: two carries + two terms
  cc_cmp43 u_col5 (
    .in_i({t[2*OPW+3], t[3*OPW+2], c3_hi, c4_lo}),
    .sum_o(s5), .cy_lo_o(c5_lo), .cy_hi_o(c5_hi)
  );

  // column 6: two carries + top term
  cc_full_add u_col6 (
    .x_i(c5_lo), .y_i(c4_hi), .z_i(t[3*OPW+3]),
    .s_o(s6), .c_o(c6)
  );

  // column 7: carry out of this bit can never be set, so it is dropped
  assign prod_o = {c6 ^ c5_hi, s6, s5, s4, s3, s2, s1, t[0]};
endmodule

// File: rtl/colmul4u_chk.sv
module colmul4u_chk
  import colmul_pkg::*;
(
  input logic [OPW-1:0] mcand_i,
  input logic [OPW-1:0] mplier_i,
  input logic [PRW-1:0] prod_o
);
  always_comb begin
    AST_LSB_AND: assert (prod_o[0] == (mcand_i[0] & mplier_i[0])); // R1
    AST_EXACT_PRODUCT: assert (int'(prod_o) == int'(mcand_i) * int'(mplier_i)); // R2
    AST_BIT1_XOR: assert (prod_o[1] == ((mcand_i[1] & mplier_i[0]) ^ (mcand_i[0] & mplier_i[1]))); // R3
    AST_NO_OVERFLOW: assert (int'(prod_o) <= MAXPROD); // R6
    AST_ZERO_OPERAND: assert (!((mcand_i == '0) || (mplier_i == '0)) || (prod_o == '0)); // R7
  end
endmodule

module cc_cmp43_chk (
  input logic [3:0] in_i,
  input logic       sum_o,
  input logic       cy_lo_o,
  input logic       cy_hi_o
);
  always_comb begin
    AST_CMP43_COUNT: assert (int'(sum_o) + 2*int'(cy_lo_o) + 4*int'(cy_hi_o) == $countones(in_i)); // R4
  end
endmodule

module cc_cmp53_chk (
  input logic [4:0] in_i,
  input logic       sum_o,
  input logic       cy_lo_o,
  input logic       cy_hi_o
);
  always_comb begin
    AST_CMP53_COUNT: assert (int'(sum_o) + 2*int'(cy_lo_o) + 4*int'(cy_hi_o) == $countones(in_i)); // R5
  end
endmodule

bind colmul4u colmul4u_chk u_colmul4u_chk (
  .mcand_i(mcand_i), .mplier_i(mplier_i), .prod_o(prod_o)
);

bind cc_cmp43 cc_cmp43_chk u_cc_cmp43_chk (
  .in_i(in_i), .sum_o(sum_o), .cy_lo_o(cy_lo_o), .cy_hi_o(cy_hi_o)
);

bind cc_cmp53 cc_cmp53_chk u_cc_cmp53_chk (
  .in_i(in_i), .sum_o(sum_o), .cy_lo_o(cy_lo_o), .cy_hi_o(cy_hi_o)
);

// File: tb/colmul4u_bench.sv
`timescale 1ns/1ps
module colmul4u_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;   // 250 MHz

  logic [3:0] a, b;
  logic [7:0] p;
  logic [3:0] v43;
  logic [4:0] v53;
  logic s43, l43, h43, s53, l53, h53;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int seen [256];

  colmul4u u_colmul4u (.mcand_i(a), .mplier_i(b), .prod_o(p));
  cc_cmp43 u_c43 (.in_i(v43), .sum_o(s43), .cy_lo_o(l43), .cy_hi_o(h43));
  cc_cmp53 u_c53 (.in_i(v53), .sum_o(s53), .cy_lo_o(l53), .cy_hi_o(h53));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (a=%0d b=%0d)", req, act, exp, a, b);
    end
  endtask

  // drive just after a rising edge, sample at the falling edge of the same cycle
  task automatic drive(input int x, input int y);
    @(posedge clk); #0.5;
    a = 4'(x); b = 4'(y);
    @(negedge clk);
  endtask

  initial begin
    a = '0; b = '0; v43 = '0; v53 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset-state zero product", int'(p), 0);
    @(posedge clk); #0.5; rst = 1'b0;

    // exhaustive operand sweep against integer model, same-cycle result
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        drive(x, y);
        chk("R2 R8 product", int'(p), x * y);
        chk("R1 bit0", int'(p[0]), (x & y) & 1);
        chk("R3 bit1", int'(p[1]), (((x >> 1) & y) ^ (x & (y >> 1))) & 1);
        chk("R6 bit7", int'(p[7]), (x * y >= 128) ? 1 : 0);
        if (x == 0 || y == 0) chk("R7 zero operand", int'(p), 0);
        seen[x*16+y] = int'(p);
      end
    end
    chk("R6 max product", seen[255], 225);
    for (int x = 0; x < 16; x++)
      for (int y = x + 1; y < 16; y++)
        chk("R9 commutative", seen[x*16+y], seen[y*16+x]);

    // back-to-back operand changes: no latency
    drive(15, 15); chk("R8 immediate 15x15", int'(p), 225);
    drive(0, 15);  chk("R8 immediate 0x15", int'(p), 0);
    drive(9, 14);  chk("R8 immediate 9x14", int'(p), 126);

    for (int k = 0; k < 16; k++) begin
      @(posedge clk); #0.5; v43 = 4'(k); @(negedge clk);
      chk("R4 cmp43 count", int'(s43) + 2*int'(l43) + 4*int'(h43), $countones(4'(k)));
    end
    for (int k = 0; k < 32; k++) begin
      @(posedge clk); #0.5; v53 = 5'(k); @(negedge clk);
      chk("R5 cmp53 count", int'(s53) + 2*int'(l53) + 4*int'(h53), $countones(5'(k)));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule